// File: doc/BRIEF.md
# Partial-Register Last-Writer Tracking Table

This block sits in the rename stage of an out-of-order core. It records, for every architectural register view, the tag of the youngest in-flight instruction that wrote it. There are several register families, and each family has four nested views: 64-bit (view 0), 32-bit (view 1), 16-bit (view 2) and 8-bit (view 3). A register index is `{family, view}`, with the view in the two low bits. Every narrower view is a sub-register of each wider view in its family.

For each write, the block decides whether a physical register is needed. A write to view 0 or view 1 sets all four views of its family and asks for a physical register. Views 2 and 3 do not clear the upper bits, so such a write is folded into view 1. It takes no physical register, only sets views 1 to 3, and depends falsely on the previous writer of view 1. The retire port removes a write and asks for a free under the same folding rule. The read port returns the distinct writer tags that a consumer of a view depends on. Occupancy counting is left to the neighbour that receives `alloc_req` and `free_req`.

Each table entry has two states: EMPTY and HELD. SET moves an entry from either state to HELD with a new tag. CLEAR moves a HELD entry to EMPTY when a removal names the tag the entry holds. Every response is registered and appears in the cycle after its request.

Top module: `lw_tracker`

## Requirements
- R1: After reset every entry is EMPTY and all outputs are 0. A read of any view then returns mask 0 and count 0.
- R2: A write to view 0 or view 1 sets all four views of its family to its tag. It raises `alloc_req` unless `wr_zero_lat` is 1, and never raises `dep_valid`.
- R3: A write to view 2 or view 3 sets only views 1, 2 and 3 of its family, and view 0 keeps its old writer. It never raises `alloc_req`.
- R4: A write to view 2 or view 3 raises `dep_valid` with `dep_tag` equal to the view-1 writer, if view 1 is HELD with a tag different from `wr_tag`. Otherwise `dep_valid` stays 0.
- R5: A write with `wr_zero_lat` = 1 updates the table as usual but raises no `alloc_req`.
- R6: A removal of view 0 or view 1 raises `free_req` unless `rm_no_free` is 1. A removal of view 2 or view 3 never raises `free_req`.
- R7: A removal clears an entry only if it holds `rm_tag`. The entries checked are all four views for a view-0 or view-1 removal, and views 1 to 3 for a view-2 or view-3 removal.
- R8: For a read of view `r`, `rd_mask` bit v is set when v >= r, view v is HELD, and no view u with r <= u < v holds the same tag. `rd_tags[6v+5:6v]` carries the tag of view v. `rd_count` is the number of set mask bits.
- R9: If a write and a removal touch the same entry in one cycle, the write wins and the entry holds the new tag.
- R10: Responses appear one cycle after the request. A read sees the table as it was before the writes and removals of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_reg | input | 4 | Written register: {family, view} |
| wr_tag | input | 6 | Tag of the writing instruction |
| wr_zero_lat | input | 1 | Write is dependency-breaking; no physical register |
| rm_valid | input | 1 | Removal request |
| rm_reg | input | 4 | Register of the removed write |
| rm_tag | input | 6 | Tag of the removed write |
| rm_no_free | input | 1 | Removed write held no physical register |
| rd_valid | input | 1 | Read query |
| rd_reg | input | 4 | Register being read |
| alloc_req | output | 1 | Physical register allocation request |
| dep_valid | output | 1 | False dependency reported |
| dep_tag | output | 6 | Tag the merged write depends on |
| free_req | output | 1 | Physical register free request |
| rd_done | output | 1 | Read result valid |
| rd_tags | output | 24 | Tag of each view of the read family, 6 bits per view |
| rd_mask | output | 4 | Views whose tag is a distinct dependency |
| rd_count | output | 3 | Number of distinct dependencies |

## Verification
The bench writes a 16-bit view over a 64-bit writer. It then reads from the widest view to show that view 0 keeps the old tag. A design that folded narrow writes into the top view would report one tag instead of two. It repeats an 8-bit write with the same tag, where a design missing the tag check would report a dependency on itself, and it writes a narrow view over an empty family, where no dependency may appear. It removes a narrow write whose entries a wider write has already replaced, so that a design that clears entries without comparing tags would erase the live writer. It also places a write and an overlapping removal in one cycle, which a design that lets the removal win would turn into an empty read.

// File: rtl/lw_pkg.sv
package lw_pkg;
    localparam int VIEWS  = 4;
    localparam int VIEW_W = 2;
    // Narrowest view that still clears the upper bits; narrower views fold into it.
    localparam logic [VIEW_W-1:0] MERGE_VIEW = 2'd1;

    function automatic logic [VIEW_W-1:0] rename_of(input logic [VIEW_W-1:0] v);
        return (v > MERGE_VIEW) ? MERGE_VIEW : v;
    endfunction

    function automatic logic clears_upper(input logic [VIEW_W-1:0] v);
        return v <= MERGE_VIEW;
    endfunction
endpackage

// File: rtl/lw_route.sv
module lw_route
    import lw_pkg::*;
(
    input  logic [VIEW_W-1:0] view,
    output logic [VIEWS-1:0]  span,
    output logic [VIEW_W-1:0] target,
    output logic              merged
);
    logic clr;

    always_comb begin
        target = rename_of(view);
        clr    = clears_upper(view);
        merged = (target != view) && !clr;
        for (int u = 0; u < VIEWS; u++) begin
            span[u] = (VIEW_W'(u) >= target) || clr;
        end
    end
endmodule

// File: rtl/lw_bank.sv
module lw_bank
    import lw_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [VIEWS-1:0]       set_en,
    input  logic [TAG_W-1:0]       set_tag,
    input  logic [VIEWS-1:0]       clr_en,
    input  logic [TAG_W-1:0]       clr_tag,
    output logic [VIEWS-1:0]       held,
    output logic [VIEWS*TAG_W-1:0] tags
);
    typedef enum logic {EMPTY, HELD} slot_e;

    for (genvar v = 0; v < VIEWS; v++) begin : g_slot
        slot_e            st;
        logic [TAG_W-1:0] tg;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st <= EMPTY;
                tg <= '0;
            end else begin
                unique case (st)
                    EMPTY: if (set_en[v]) begin
                        st <= HELD;
                        tg <= set_tag;
                    end
                    HELD: if (set_en[v]) begin
                        tg <= set_tag;
                    end else if (clr_en[v] && tg == clr_tag) begin
                        st <= EMPTY;
                    end
                    default: st <= EMPTY;
                endcase
            end
        end

        assign held[v]                  = (st == HELD);
        assign tags[v*TAG_W +: TAG_W]   = tg;
    end
endmodule

// File: rtl/lw_gather.sv
module lw_gather
    import lw_pkg::*;
#(
    parameter int TAG_W = 6,
    localparam int CNT_W = $clog2(VIEWS + 1)
) (
    input  logic [VIEW_W-1:0]      view,
    input  logic [VIEWS-1:0]       held,
    input  logic [VIEWS*TAG_W-1:0] tags,
    output logic [VIEWS-1:0]       keep,
    output logic [CNT_W-1:0]       count
);
    logic [VIEWS-1:0] cand;

    always_comb begin
        count = '0;
        for (int v = 0; v < VIEWS; v++) begin
            cand[v] = held[v] && (VIEW_W'(v) >= view);
        end
        for (int v = 0; v < VIEWS; v++) begin
            keep[v] = cand[v];
            for (int u = 0; u < v; u++) begin
                if (cand[u] && tags[u*TAG_W +: TAG_W] == tags[v*TAG_W +: TAG_W]) begin
                    keep[v] = 1'b0;
                end
            end
            count = count + CNT_W'(keep[v]);
        end
    end
endmodule

// File: rtl/lw_tracker.sv
module lw_tracker
    import lw_pkg::*;
#(
    parameter int NUM_FAM = 4,
    parameter int TAG_W   = 6,
    localparam int FAM_W  = (NUM_FAM > 1) ? $clog2(NUM_FAM) : 1,
    localparam int REG_W  = FAM_W + VIEW_W,
    localparam int CNT_W  = $clog2(VIEWS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_valid,
    input  logic [REG_W-1:0]       wr_reg,
    input  logic [TAG_W-1:0]       wr_tag,
    input  logic                   wr_zero_lat,
    input  logic                   rm_valid,
    input  logic [REG_W-1:0]       rm_reg,
    input  logic [TAG_W-1:0]       rm_tag,
    input  logic                   rm_no_free,
    input  logic                   rd_valid,
    input  logic [REG_W-1:0]       rd_reg,
    output logic                   alloc_req,
    output logic                   dep_valid,
    output logic [TAG_W-1:0]       dep_tag,
    output logic                   free_req,
    output logic                   rd_done,
    output logic [VIEWS*TAG_W-1:0] rd_tags,
    output logic [VIEWS-1:0]       rd_mask,
    output logic [CNT_W-1:0]       rd_count
);
    logic [FAM_W-1:0]  wr_fam, rm_fam, rd_fam;
    logic [VIEWS-1:0]  wr_span, rm_span;
    logic [VIEW_W-1:0] wr_tgt, rm_tgt;
    logic              wr_merged, rm_merged;

    assign wr_fam = wr_reg[REG_W-1:VIEW_W];
    assign rm_fam = rm_reg[REG_W-1:VIEW_W];
    assign rd_fam = rd_reg[REG_W-1:VIEW_W];

    lw_route u_wr_route (.view(wr_reg[VIEW_W-1:0]), .span(wr_span), .target(wr_tgt), .merged(wr_merged));
    lw_route u_rm_route (.view(rm_reg[VIEW_W-1:0]), .span(rm_span), .target(rm_tgt), .merged(rm_merged));

    logic [VIEWS-1:0]       row_held [NUM_FAM];
    logic [VIEWS*TAG_W-1:0] row_tags [NUM_FAM];

    for (genvar f = 0; f < NUM_FAM; f++) begin : g_fam
        logic [VIEWS-1:0] set_en, clr_en;
        assign set_en = (wr_valid && wr_fam == FAM_W'(f)) ? wr_span : '0;
        assign clr_en = (rm_valid && rm_fam == FAM_W'(f)) ? rm_span : '0;

        lw_bank #(.TAG_W(TAG_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .set_en(set_en), .set_tag(wr_tag),
            .clr_en(clr_en), .clr_tag(rm_tag),
            .held(row_held[f]), .tags(row_tags[f])
        );
    end

    logic [VIEWS*TAG_W-1:0] wr_row_tags, rd_row_tags;
    logic [VIEWS-1:0]       wr_row_held, rd_row_held;
    logic [TAG_W-1:0]       cur_tag;
    logic                   cur_held;
    logic [VIEWS-1:0]       rd_keep;
    logic [CNT_W-1:0]       rd_cnt_c;

    assign wr_row_tags = row_tags[wr_fam];
    assign wr_row_held = row_held[wr_fam];
    assign rd_row_tags = row_tags[rd_fam];
    assign rd_row_held = row_held[rd_fam];
    assign cur_tag     = wr_row_tags[wr_tgt*TAG_W +: TAG_W];
    assign cur_held    = wr_row_held[wr_tgt];

    lw_gather #(.TAG_W(TAG_W)) u_gather (
        .view(rd_reg[VIEW_W-1:0]), .held(rd_row_held), .tags(rd_row_tags),
        .keep(rd_keep), .count(rd_cnt_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_req <= 1'b0;
            dep_valid <= 1'b0;
            dep_tag   <= '0;
            free_req  <= 1'b0;
            rd_done   <= 1'b0;
            rd_tags   <= '0;
            rd_mask   <= '0;
            rd_count  <= '0;
        end else begin
            alloc_req <= wr_valid && !wr_merged && !wr_zero_lat;
            dep_valid <= wr_valid && wr_merged && cur_held && (cur_tag != wr_tag);
            dep_tag   <= cur_tag;
            free_req  <= rm_valid && !rm_merged && !rm_no_free;
            rd_done   <= rd_valid;
            rd_tags   <= rd_row_tags;
            rd_mask   <= rd_valid ? rd_keep : '0;
            rd_count  <= rd_valid ? rd_cnt_c : '0;
        end
    end
endmodule

// File: rtl/lw_tracker_chk.sv
module lw_tracker_chk
    import lw_pkg::*;
#(
    parameter int NUM_FAM = 4,
    parameter int TAG_W   = 6,
    localparam int FAM_W  = (NUM_FAM > 1) ? $clog2(NUM_FAM) : 1,
    localparam int REG_W  = FAM_W + VIEW_W,
    localparam int CNT_W  = $clog2(VIEWS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_valid,
    input logic [REG_W-1:0]       wr_reg,
    input logic [TAG_W-1:0]       wr_tag,
    input logic                   wr_zero_lat,
    input logic                   rm_valid,
    input logic [REG_W-1:0]       rm_reg,
    input logic                   rm_no_free,
    input logic                   rd_valid,
    input logic [REG_W-1:0]       rd_reg,
    input logic                   alloc_req,
    input logic                   dep_valid,
    input logic [TAG_W-1:0]       dep_tag,
    input logic                   free_req,
    input logic                   rd_done,
    input logic [VIEWS*TAG_W-1:0] rd_tags,
    input logic [VIEWS-1:0]       rd_mask,
    input logic [CNT_W-1:0]       rd_count
);
    assert_alloc_wide_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> ($past(wr_valid) && $past(wr_reg[VIEW_W-1:0]) <= MERGE_VIEW));

    assert_merge_no_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dep_valid |-> !alloc_req);

    assert_dep_other_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dep_valid |-> ($past(wr_valid) && dep_tag != $past(wr_tag)));

    assert_zero_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> !$past(wr_zero_lat));

    assert_free_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        free_req |-> ($past(rm_valid) && !$past(rm_no_free) && $past(rm_reg[VIEW_W-1:0]) <= MERGE_VIEW));

    assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_done);

    assert_mask_above_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> ((rd_mask & ((VIEWS'(1) << $past(rd_reg[VIEW_W-1:0])) - VIEWS'(1))) == '0));

    assert_count_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (rd_count == CNT_W'($countones(rd_mask))));

    for (genvar i = 0; i < VIEWS; i++) begin : g_ui
        for (genvar j = i + 1; j < VIEWS; j++) begin : g_uj
            assert_tags_unique_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_done && rd_mask[i] && rd_mask[j]) |->
                (rd_tags[i*TAG_W +: TAG_W] != rd_tags[j*TAG_W +: TAG_W]));
        end
    end
endmodule

bind lw_tracker lw_tracker_chk #(.NUM_FAM(NUM_FAM), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_tag(wr_tag), .wr_zero_lat(wr_zero_lat),
    .rm_valid(rm_valid), .rm_reg(rm_reg), .rm_no_free(rm_no_free),
    .rd_valid(rd_valid), .rd_reg(rd_reg),
    .alloc_req(alloc_req), .dep_valid(dep_valid), .dep_tag(dep_tag), .free_req(free_req),
    .rd_done(rd_done), .rd_tags(rd_tags), .rd_mask(rd_mask), .rd_count(rd_count)
);

// File: tb/lw_tracker_test.sv
module lw_tracker_test;
    localparam int PERIOD = 10;
    localparam int EW     = 41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 0, wr_zero_lat = 0, rm_valid = 0, rm_no_free = 0, rd_valid = 0;
    logic [3:0]  wr_reg = 0, rm_reg = 0, rd_reg = 0;
    logic [5:0]  wr_tag = 0, rm_tag = 0;
    logic        alloc_req, dep_valid, free_req, rd_done;
    logic [5:0]  dep_tag;
    logic [23:0] rd_tags;
    logic [3:0]  rd_mask;
    logic [2:0]  rd_count;

    typedef struct {
        logic [EW-1:0] v;
        string         req;
    } item_t;
    item_t q[$];

    int  total = 0;
    int  bad = 0;
    bit  ended = 0;

    always #(PERIOD/2) clk = ~clk;

    lw_tracker uut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_tag(wr_tag), .wr_zero_lat(wr_zero_lat),
        .rm_valid(rm_valid), .rm_reg(rm_reg), .rm_tag(rm_tag), .rm_no_free(rm_no_free),
        .rd_valid(rd_valid), .rd_reg(rd_reg),
        .alloc_req(alloc_req), .dep_valid(dep_valid), .dep_tag(dep_tag), .free_req(free_req),
        .rd_done(rd_done), .rd_tags(rd_tags), .rd_mask(rd_mask), .rd_count(rd_count)
    );

    function automatic logic [23:0] mask_tags(logic [23:0] t, logic [3:0] m);
        logic [23:0] r;
        for (int v = 0; v < 4; v++) r[v*6 +: 6] = m[v] ? t[v*6 +: 6] : 6'd0;
        return r;
    endfunction

    task automatic step(input logic w, input logic [3:0] wrg, input logic [5:0] wt, input logic wz,
                        input logic m, input logic [3:0] mrg, input logic [5:0] mt, input logic mnf,
                        input logic r, input logic [3:0] rrg,
                        input logic ea, input logic ed, input logic [5:0] edt, input logic ef,
                        input logic [3:0] em, input logic [2:0] ec,
                        input logic [5:0] t0, input logic [5:0] t1, input logic [5:0] t2, input logic [5:0] t3,
                        input string req);
        item_t it;
        @(negedge clk);
        wr_valid = w;  wr_reg = wrg; wr_tag = wt; wr_zero_lat = wz;
        rm_valid = m;  rm_reg = mrg; rm_tag = mt; rm_no_free = mnf;
        rd_valid = r;  rd_reg = rrg;
        it.v   = {ea, ed, ed ? edt : 6'd0, ef, r, em, ec, mask_tags({t3, t2, t1, t0}, em)};
        it.req = req;
        q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        logic [EW-1:0] act;
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (q.size() > 0) begin
                it  = q.pop_front();
                act = {alloc_req, dep_valid, dep_valid ? dep_tag : 6'd0, free_req, rd_done,
                       rd_mask, rd_count, mask_tags(rd_tags, rd_mask)};
                total++;
                if (act !== it.v) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act, it.v);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (2000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        //   w wreg tag z | m mreg tag nf | r rreg | alloc dep dtag free | mask cnt | t0..t3
        step(0, 0, 0, 0,  0, 0, 0, 0,  0, 0,  0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R1");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 0,  0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R1");
        step(1, 0, 5, 0,  0, 0, 0, 0,  0, 0,  1, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R2");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 0,  0, 0, 0, 0,  4'b0001, 1,  5, 0, 0, 0, "R8");
        step(1, 2, 7, 0,  0, 0, 0, 0,  0, 0,  0, 1, 5, 0,  4'b0000, 0,  0, 0, 0, 0, "R4");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 0,  0, 0, 0, 0,  4'b0011, 2,  5, 7, 0, 0, "R3");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 2,  0, 0, 0, 0,  4'b0100, 1,  0, 0, 7, 0, "R8");
        step(1, 3, 7, 0,  0, 0, 0, 0,  0, 0,  0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R4");
        step(1, 1, 9, 1,  0, 0, 0, 0,  0, 0,  0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R5");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 0,  0, 0, 0, 0,  4'b0001, 1,  9, 0, 0, 0, "R5");
        step(0, 0, 0, 0,  1, 2, 7, 0,  0, 0,  0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R6");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 1,  0, 0, 0, 0,  4'b0010, 1,  0, 9, 0, 0, "R7");
        step(0, 0, 0, 0,  1, 0, 9, 0,  0, 0,  0, 0, 0, 1,  4'b0000, 0,  0, 0, 0, 0, "R6");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 0,  0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R7");
        step(1, 4, 3, 0,  0, 0, 0, 0,  0, 0,  1, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R2");
        step(1, 7, 4, 0,  0, 0, 0, 0,  0, 0,  0, 1, 3, 0,  4'b0000, 0,  0, 0, 0, 0, "R4");
        step(0, 0, 0, 0,  1, 7, 4, 0,  0, 0,  0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R6");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 4,  0, 0, 0, 0,  4'b0001, 1,  3, 0, 0, 0, "R7");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 5,  0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R7");
        step(1, 10, 8, 0, 0, 0, 0, 0,  0, 0,  0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R4");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 8,  0, 0, 0, 0,  4'b0010, 1,  0, 8, 0, 0, "R3");
        step(1, 12, 1, 0, 0, 0, 0, 0,  0, 0,  1, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R2");
        step(1, 12, 2, 0, 1, 15, 1, 0, 0, 0,  1, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R9");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 13, 0, 0, 0, 0,  4'b0010, 1,  0, 2, 0, 0, "R9");
        step(1, 12, 6, 0, 0, 0, 0, 0,  1, 12, 1, 0, 0, 0,  4'b0001, 1,  2, 0, 0, 0, "R10");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 12, 0, 0, 0, 0,  4'b0001, 1,  6, 0, 0, 0, "R10");
        step(0, 0, 0, 0,  1, 12, 6, 1, 0, 0,  0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R6");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, 12, 0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R7");
        step(0, 0, 0, 0,  0, 0, 0, 0,  0, 0,  0, 0, 0, 0,  4'b0000, 0,  0, 0, 0, 0, "R1");
        repeat (3) @(posedge clk);
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule